// File: doc/BRIEF.md
# Watchdog Timeout Configuration Port over SPI

This block is a serial slave that lets a host processor read and change the two-bit timeout selection of a separate watchdog. The host talks to it with one-byte instructions over a mode 0 SPI link. Bits move most significant first. SI is taken on the rising SCK edge and SO moves on the falling edge. The serial pins are brought into the system clock domain through two-stage synchronisers, and all decoding is done on edges of the synchronised copies. Because of this, the SCK clock may stop and restart at any point inside a byte.

Changing the timeout needs two separate transactions, so that one corrupted transfer cannot change it. The first transaction arms a change latch. The second sends the set-timeout instruction and its data byte. The data byte is written only if CS_N returns high right after its eighth bit and every reserved bit is zero. A write that is accepted clears the latch. It also starts a busy period of fixed length that stands in for a nonvolatile programming cycle. During the busy period only the read instruction is honoured, and a read returns all ones.

Top module: `wdtCfgSpi`

## Requirements
- R1: SI is sampled on each rising SCK edge, most significant bit first, and the first bit of a transaction is taken on the first rising edge after CS_N falls. SO changes on falling SCK edges. If SCK stops for any length of time in the middle of a byte, the partial byte is kept and shifting resumes where it left off.
- R2: After reset, soEn is 0 and timeoutSel is 2'b00. soEn is 1 only during a read: it rises on the first falling SCK edge after the read opcode and drops once CS_N is high. It stays 0 for all other instructions.
- R3: Opcode 8'h06 sets the change latch and opcode 8'h04 clears it. A write sent after an arm followed by a disarm does not change timeoutSel.
- R4: Opcode 8'h01 is followed by one data byte. Bit 4 of that byte goes to timeoutSel[1] and bit 3 to timeoutSel[0]. The write happens only if the latch is set and CS_N rises after the eighth data bit with no further rising SCK edge in between. If an extra SCK edge occurs, the write is dropped and the latch keeps its value.
- R5: A data byte with any of bits 7, 6, 5, 2, 1 or 0 set is rejected. timeoutSel does not change, no busy period starts, and the latch stays set.
- R6: An accepted write clears the latch and starts a busy period of BUSY_CYCLES system clocks. During that period opcodes 8'h06, 8'h04 and 8'h01 have no effect.
- R7: Opcode 8'h05 is followed by SO output of the byte {3'b000, timeoutSel[1], timeoutSel[0], 3'b000}, MSB first. If clocking continues past that byte, the same byte is sent again.
- R8: A read whose opcode completes during the busy period drives SO high for every data bit.
- R9: Any other opcode is ignored. Further bits up to the next rise of CS_N are not decoded, and soEn stays 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous, may pause |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid when soEn is 1 |
| soEn | output | 1 | Output enable for the SO pad driver |
| timeoutSel | output | 2 | Timeout selection sent to the watchdog |

## Verification
Writes are tried in four forms: without arming, armed, armed and then disarmed, and armed but with a ninth SCK edge. Together these separate the latch condition from the condition on CS_N timing. Data bytes with reserved bits set show whether rejection leaves the latch armed, and reads issued inside and outside the busy window show whether the all-ones response is tied to the programming cycle. An unknown opcode is followed by a byte that looks like the arm opcode, which exposes a decoder that does not stay idle until the next CS_N rise. A long SCK pause inside an opcode checks that shifting is held and then resumed.

// File: rtl/wdtcfg_pkg.sv
package wdtcfg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_ARM    = 8'h06;
  localparam logic [BYTE_W-1:0] OP_DISARM = 8'h04;
  localparam logic [BYTE_W-1:0] OP_SETTO  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_DATA,
    ST_COMMIT,
    ST_READ,
    ST_SKIP
  } ctlState_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic commit;
    logic loadRead;
    logic shiftOut;
    logic endRead;
  } ctlStrb_t;

endpackage

// File: rtl/wdtcfg_sync.sv
module wdtcfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/wdtcfg_ctrl.sv
module wdtcfg_ctrl
  import wdtcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              csS,
  input  logic              siS,
  input  logic              busy,
  output ctlStrb_t          strb,
  output logic [BYTE_W-1:0] wrData
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctlState_t         state;
  logic              sckQ, csQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shifter;
  logic [BYTE_W-1:0] nextByte;
  logic              sckRise, sckFall, csRise, csFall;
  logic              lastBit, opDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= sckS;
      csQ  <= csS;
    end
  end

  assign sckRise  = sckS & ~sckQ;
  assign sckFall  = ~sckS & sckQ;
  assign csRise   = csS & ~csQ;
  assign csFall   = ~csS & csQ;
  assign nextByte = {shifter[BYTE_W-2:0], siS};
  assign lastBit  = (bitCnt == LAST_BIT);
  assign opDone   = (state == ST_OPC) && sckRise && lastBit;
  assign wrData   = shifter;

  function automatic ctlState_t afterOpcode(input logic [BYTE_W-1:0] op, input logic isBusy);
    if (op == OP_SETTO && !isBusy) return ST_DATA;
    if (op == OP_READ)             return ST_READ;
    return ST_SKIP;
  endfunction

  always_comb begin
    strb          = '0;
    strb.setLatch = opDone && (nextByte == OP_ARM) && !busy;
    strb.clrLatch = opDone && (nextByte == OP_DISARM) && !busy;
    strb.loadRead = opDone && (nextByte == OP_READ);
    strb.commit   = csRise && (state == ST_COMMIT);
    strb.shiftOut = (state == ST_READ) && sckFall;
    strb.endRead  = csS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shifter <= '0;
    end else if (csRise) begin
      state <= ST_IDLE;
    end else if (csFall) begin
      state  <= ST_OPC;
      bitCnt <= '0;
    end else if (sckRise) begin
      case (state)
        ST_OPC: begin
          shifter <= nextByte;
          bitCnt  <= bitCnt + 1'b1;
          if (lastBit) state <= afterOpcode(nextByte, busy);
        end
        ST_DATA: begin
          shifter <= nextByte;
          bitCnt  <= bitCnt + 1'b1;
          if (lastBit) state <= ST_COMMIT;
        end
        ST_COMMIT: state <= ST_SKIP;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wdtcfg_dp.sv
module wdtcfg_dp
  import wdtcfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter int WD_LSB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              busy,
  output logic              latch,
  output logic [1:0]        timeoutSel,
  output logic              so,
  output logic              soEn
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BYTE_W-1:0] FIELD_MASK = BYTE_W'(2'b11) << WD_LSB;

  logic [BUSY_W-1:0] busyCnt;
  logic [BYTE_W-1:0] outReg;
  logic [BYTE_W-1:0] regImage;
  logic              reservedOk, accept;

  assign busy       = (busyCnt != '0);
  assign reservedOk = ((wrData & ~FIELD_MASK) == '0);
  assign accept     = strb.commit && latch && reservedOk && !busy;
  assign regImage   = BYTE_W'(timeoutSel) << WD_LSB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (accept)          busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latch      <= 1'b0;
      timeoutSel <= 2'b00;
    end else if (accept) begin
      latch      <= 1'b0;
      timeoutSel <= wrData[WD_LSB +: 2];
    end else if (strb.setLatch) begin
      latch <= 1'b1;
    end else if (strb.clrLatch) begin
      latch <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      so     <= 1'b0;
      soEn   <= 1'b0;
    end else begin
      if (strb.loadRead) begin
        outReg <= busy ? '1 : regImage;
      end else if (strb.shiftOut) begin
        so     <= outReg[BYTE_W-1];
        outReg <= {outReg[BYTE_W-2:0], outReg[BYTE_W-1]};
      end
      if (strb.endRead)       soEn <= 1'b0;
      else if (strb.shiftOut) soEn <= 1'b1;
    end
  end

endmodule

// File: rtl/wdtCfgSpi.sv
module wdtCfgSpi
  import wdtcfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2,
  parameter int WD_LSB = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  output logic       so,
  output logic       soEn,
  output logic [1:0] timeoutSel
);

  logic              csS, sckS, siS;
  logic              busy, latch;
  ctlStrb_t          strb;
  logic [BYTE_W-1:0] wrData;

  wdtcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sck, si}),
    .dout({csS, sckS, siS})
  );

  wdtcfg_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sckS  (sckS),
    .csS   (csS),
    .siS   (siS),
    .busy  (busy),
    .strb  (strb),
    .wrData(wrData)
  );

  wdtcfg_dp #(.BUSY_CYCLES(BUSY_CYCLES), .WD_LSB(WD_LSB)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .busy      (busy),
    .latch     (latch),
    .timeoutSel(timeoutSel),
    .so        (so),
    .soEn      (soEn)
  );

endmodule

// File: rtl/wdtcfg_chk.sv
module wdtcfg_chk
  import wdtcfg_pkg::*;
#(
  parameter int WD_LSB = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              soEn,
  input logic [1:0]        timeoutSel,
  input logic              csSync,
  input ctlStrb_t          strb,
  input logic [BYTE_W-1:0] wrData,
  input logic              busy,
  input logic              latch
);

  localparam logic [BYTE_W-1:0] RSV_MASK = ~(BYTE_W'(2'b11) << WD_LSB);

  a_r2_release_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> !soEn);

  a_r4_timeout_moves_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutSel != $past(timeoutSel)) |-> $past(strb.commit));

  a_r5_reject_keeps_latch: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && latch && ((wrData & RSV_MASK) != '0)) |=> (latch && !busy));

  a_r6_write_starts_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && latch && !busy && ((wrData & RSV_MASK) == '0)) |=> (busy && !latch));

  a_r6_arm_not_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latch) |-> $past(!busy));

  a_r6_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.commit);

endmodule

bind wdtCfgSpi wdtcfg_chk #(.WD_LSB(WD_LSB)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .soEn      (soEn),
  .timeoutSel(timeoutSel),
  .csSync    (csS),
  .strb      (strb),
  .wrData    (wrData),
  .busy      (busy),
  .latch     (latch)
);

// File: tb/tb_wdtCfgSpi.sv
`timescale 1ns/1ps
module tb_wdtCfgSpi;

  localparam int BUSY = 2000;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rstN, csN, sck, si;
  logic so, soEn;
  logic [1:0] timeoutSel;

  int checks = 0;
  int errors = 0;

  logic [7:0] expQ[$];
  string      reqQ[$];
  logic [7:0] gotByte;
  event       readDone;
  logic       enAll, enAny;

  always #2 clk = ~clk;

  wdtCfgSpi #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .so(so), .soEn(soEn), .timeoutSel(timeoutSel)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Monitor: pops expected read bytes and compares with what SO delivered
  initial begin
    forever begin
      @(readDone);
      chk(reqQ.pop_front(), gotByte, expQ.pop_front());
    end
  end

  task automatic spiByte(input logic [7:0] tx, input bit cap, output logic [7:0] rx,
                         input int pauseAfter);
    rx = '0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      #(HALF - 4);
      if (cap) rx[i] = so;
      enAll = enAll & soEn;
      enAny = enAny | soEn;
      #4;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
      if (pauseAfter == i) #3000;
    end
  endtask

  task automatic endXfer();
    #HALF;
    csN = 1'b1;
    #(HALF * 3);
  endtask

  task automatic cmd(input logic [7:0] op, input int pauseAfter);
    logic [7:0] d;
    csN = 1'b0;
    #HALF;
    spiByte(op, 1'b0, d, pauseAfter);
    endXfer();
  endtask

  task automatic cmdData(input logic [7:0] op, input logic [7:0] data, input bit extra);
    logic [7:0] d;
    csN = 1'b0;
    #HALF;
    enAny = 1'b0;
    spiByte(op, 1'b0, d, -1);
    spiByte(data, 1'b0, d, -1);
    if (extra) begin
      #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    end
    endXfer();
  endtask

  // Driver: pushes expectation, then clocks out data bytes
  task automatic readReg(input logic [7:0] exp, input string req, input int nBytes);
    logic [7:0] d;
    csN = 1'b0;
    #HALF;
    enAny = 1'b0;
    spiByte(8'h05, 1'b0, d, -1);
    chk("R2 soEn low during opcode", enAny, 0);
    for (int b = 0; b < nBytes; b++) begin
      expQ.push_back(exp);
      reqQ.push_back(req);
      enAll = 1'b1;
      spiByte(8'h00, 1'b1, gotByte, -1);
      ->readDone;
      #1;
      chk("R2 soEn high through read", enAll, 1);
    end
    endXfer();
    chk("R2 soEn released after CS_N high", soEn, 0);
  endtask

  task automatic waitBusy();
    #(BUSY * 4 + 400);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; si = 1'b0;
    enAll = 1'b1; enAny = 1'b0;
    #101;
    chk("R2 reset soEn", soEn, 0);
    chk("R2 reset timeoutSel", timeoutSel, 0);
    rstN = 1'b1;
    #100;

    readReg(8'h00, "R7 read after reset", 1);

    cmdData(8'h01, 8'h10, 1'b0);
    chk("R4 write without arm ignored", timeoutSel, 0);

    cmd(8'h06, -1);
    cmdData(8'h01, 8'h10, 1'b0);
    chk("R4 armed write", timeoutSel, 2);
    readReg(8'hFF, "R8 read during busy", 1);
    waitBusy();
    readReg(8'h10, "R7 read value 2", 1);

    cmdData(8'h01, 8'h08, 1'b0);
    chk("R6 latch consumed by write", timeoutSel, 2);

    cmd(8'h06, -1);
    cmdData(8'h01, 8'h19, 1'b0);
    chk("R5 reserved bit rejected", timeoutSel, 2);
    readReg(8'h10, "R5 no busy after reject", 1);
    cmdData(8'h01, 8'h08, 1'b0);
    chk("R5 latch kept after reject", timeoutSel, 1);
    waitBusy();

    cmd(8'h06, -1);
    cmd(8'h04, -1);
    cmdData(8'h01, 8'h18, 1'b0);
    chk("R3 disarm blocks write", timeoutSel, 1);

    cmd(8'h06, -1);
    cmdData(8'h01, 8'h18, 1'b1);
    chk("R4 extra SCK edge cancels write", timeoutSel, 1);
    cmdData(8'h01, 8'h18, 1'b0);
    chk("R4 latch survives cancelled write", timeoutSel, 3);

    cmd(8'h06, -1);
    waitBusy();
    cmdData(8'h01, 8'h00, 1'b0);
    chk("R6 arm during busy ignored", timeoutSel, 3);

    cmdData(8'hAB, 8'h06, 1'b0);
    chk("R9 soEn low for unknown opcode", enAny, 0);
    cmdData(8'h01, 8'h00, 1'b0);
    chk("R9 trailing byte not decoded", timeoutSel, 3);

    cmd(8'h06, 3);
    cmdData(8'h01, 8'h00, 1'b0);
    chk("R1 opcode survives SCK pause", timeoutSel, 0);
    waitBusy();

    cmd(8'h06, -1);
    cmdData(8'h01, 8'h08, 1'b0);
    chk("R4 write value 1", timeoutSel, 1);
    waitBusy();
    readReg(8'h08, "R7 repeated read byte", 2);

    #200;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule